// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block derives a slow clock from a fast reference clock. It alternates between two integer divide ratios, so the average output frequency can fall between them. For example, 24 MHz can be brought to about 32.768 kHz. The block runs a group of A-ratio periods, then a group of B-ratio periods, and repeats the two groups. When the dual function is off, only the A ratio is used. All outputs are registered in the reference domain. A one-cycle enable pulse marks the end of each output period. A square wave is high for the first half of each period.

Two 32-bit control words set the behaviour:

- Control word 0 holds the A ratio, the B ratio, the dual enable, an input gate and an output gate.
- Control word 1 holds the A and B group lengths and a bypass.

When the input gate is low, the counting logic is held at its start point. The output gate only opens or closes while the wave is low. Divider fields that change while the block runs are picked up at the end of the current group. A safe reprogramming sequence is:

1. Close both gates.
2. Write the fields.
3. Open the input gate.
4. Let it settle.
5. Open the output gate.

Top module: `dmod_clk_div`

## Requirements
- R1: While reset is asserted, and after reset with both control words zero, `tick_o` and `wave_o` are low.
- R2: Each field holds its value minus one. With dual off (ctrl0 bit 28 = 0), input gate (ctrl0 bit 31) and output gate (ctrl0 bit 30) set and bypass (ctrl1 bit 24) clear, `tick_o` pulses once every A+1 reference cycles. A is ctrl0 bits 11:0.
- R3: In a period of ratio R, `wave_o` is high for floor(R/2) cycles at the start of the period. It is low for the remaining cycles, and `tick_o` falls on the last of them.
- R4: With dual set, the block emits MA+1 periods of ratio A+1, then MB+1 periods of ratio B+1, and repeats. B is ctrl0 bits 23:12, MA is ctrl1 bits 11:0 and MB is ctrl1 bits 23:12.
- R5: With fields A=732, B=731, MA=7 and MB=10, one full group of 19 periods lasts 13916 reference cycles. This is about 32768 Hz from 24 MHz.
- R6: While the input gate is low, both outputs stay low. When the gate rises, the first output period starts on the next cycle, in the A phase, with a full high time.
- R7: The output gate changes only in the low phase of the wave. Closing it during a high phase lets that high phase finish. Opening it during a high phase emits nothing until the following full period.
- R8: A change of ratio or count fields while the gates are open takes effect only at the end of the current group.
- R9: With bypass and both gates set, `tick_o` is high every cycle and `wave_o` is low, whatever the divider fields hold. With bypass set but the input gate low, `tick_o` stays low.
- R10: A ratio field of zero (ratio 1) gives `tick_o` high on every cycle, with `wave_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl0_i | input | 32 | A ratio [11:0], B ratio [23:12], dual [28], output gate [30], input gate [31] |
| ctrl1_i | input | 32 | A count [11:0], B count [23:12], bypass [24] |
| tick_o | output | 1 | One-cycle pulse at the end of each output period |
| wave_o | output | 1 | Divided square wave |

## Verification
A period counter that slips or wraps at the wrong value shows at the ports as a wrong spacing between `tick_o` pulses, or a wrong high count on `wave_o`, within one output period. A wrong group count or phase flag only becomes visible at the next A/B boundary. It appears as an out-of-place period length within one full group, so the bench compares whole sequences of periods rather than single periods. A wrong output-gate state appears as a shortened high pulse in the cycle the gate moves.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

    localparam int FW = 12;

    localparam int C0_A_LSB   = 0;
    localparam int C0_B_LSB   = 12;
    localparam int C0_DUAL    = 28;
    localparam int C0_OGATE   = 30;
    localparam int C0_IGATE   = 31;
    localparam int C1_MA_LSB  = 0;
    localparam int C1_MB_LSB  = 12;
    localparam int C1_BYPASS  = 24;

    typedef struct packed {
        logic [FW-1:0] ra;
        logic [FW-1:0] rb;
        logic [FW-1:0] ma;
        logic [FW-1:0] mb;
        logic          dual;
    } div_cfg_t;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    function automatic div_cfg_t decode_cfg(input logic [31:0] w0, input logic [31:0] w1);
        div_cfg_t c;
        c.ra   = w0[C0_A_LSB +: FW];
        c.rb   = w0[C0_B_LSB +: FW];
        c.ma   = w1[C1_MA_LSB +: FW];
        c.mb   = w1[C1_MB_LSB +: FW];
        c.dual = w0[C0_DUAL];
        return c;
    endfunction

endpackage

// File: rtl/dmod_seq.sv
module dmod_seq
    import dmod_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          period_end,
    input  div_cfg_t      live,
    output logic [FW-1:0] ratio_cur,
    output logic [FW-1:0] ratio_nxt
);

    typedef struct packed {
        div_cfg_t      sh;
        phase_e        ph;
        logic [FW-1:0] rep;
    } seq_t;

    seq_t          s_d, s_q;
    logic [FW-1:0] cnt_lim;

    always_comb begin
        s_d     = s_q;
        cnt_lim = (s_q.ph == PH_B) ? s_q.sh.mb : s_q.sh.ma;
        if (!active) begin
            s_d.sh  = live;
            s_d.ph  = PH_A;
            s_d.rep = '0;
        end else if (period_end) begin
            if (s_q.rep == cnt_lim) begin
                s_d.rep = '0;
                s_d.sh  = live;
                s_d.ph  = (live.dual && s_q.ph == PH_A) ? PH_B : PH_A;
            end else begin
                s_d.rep = s_q.rep + 1'b1;
            end
        end
        ratio_cur = (s_q.ph == PH_B) ? s_q.sh.rb : s_q.sh.ra;
        ratio_nxt = (s_d.ph == PH_B) ? s_d.sh.rb : s_d.sh.ra;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the B phase is only ever entered with dual latched
    p_phase_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_B) |-> s_q.sh.dual);

endmodule

// File: rtl/dmod_period.sv
module dmod_period
    import dmod_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [FW-1:0] ratio_cur,
    output logic          period_end,
    output logic          run_d_o,
    output logic [FW-1:0] cnt_d_o
);

    typedef struct packed {
        logic          run;
        logic [FW-1:0] cnt;
    } per_t;

    per_t p_d, p_q;

    always_comb begin
        period_end = p_q.run && (p_q.cnt == ratio_cur);
        p_d        = p_q;
        if (!active) begin
            p_d.run = 1'b0;
            p_d.cnt = '0;
        end else if (!p_q.run) begin
            p_d.run = 1'b1;
            p_d.cnt = '0;
        end else if (period_end) begin
            p_d.cnt = '0;
        end else begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
        run_d_o = p_d.run;
        cnt_d_o = p_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R2: the period counter never passes the ratio chosen by the sequencer
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.run |-> (p_q.cnt <= ratio_cur));

endmodule

// File: rtl/dmod_outgate.sv
module dmod_outgate
    import dmod_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  logic [FW-1:0] cnt_d,
    input  logic [FW-1:0] ratio_d,
    input  logic          byp_on,
    input  logic          gate_req,
    output logic          tick_o,
    output logic          wave_o
);

    typedef struct packed {
        logic gate;
        logic tick;
        logic wave;
    } og_t;

    og_t         o_d, o_q;
    logic [FW:0] half_d;
    logic        low_ph;

    always_comb begin
        half_d = ({1'b0, ratio_d} + 1'b1) >> 1;
        low_ph = !run_d || ({1'b0, cnt_d} >= half_d);
        o_d.gate = low_ph ? gate_req : o_q.gate;
        o_d.wave = o_d.gate && run_d && ({1'b0, cnt_d} < half_d);
        o_d.tick = o_d.gate && (byp_on || (run_d && cnt_d == ratio_d));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tick_o = o_q.tick;
    assign wave_o = o_q.wave;

    // R3: the end-of-period pulse always falls in the low phase
    p_tick_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> !wave_o);

endmodule

// File: rtl/dmod_clk_div.sv
module dmod_clk_div
    import dmod_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ctrl0_i,
    input  logic [31:0] ctrl1_i,
    output logic        tick_o,
    output logic        wave_o
);

    div_cfg_t      live;
    logic          in_gate, bypass, active, byp_on;
    logic          period_end, run_d;
    logic [FW-1:0] cnt_d, ratio_cur, ratio_nxt;

    always_comb begin
        live    = decode_cfg(ctrl0_i, ctrl1_i);
        in_gate = ctrl0_i[C0_IGATE];
        bypass  = ctrl1_i[C1_BYPASS];
        active  = in_gate && !bypass;
        byp_on  = in_gate && bypass;
    end

    dmod_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .period_end (period_end),
        .live       (live),
        .ratio_cur  (ratio_cur),
        .ratio_nxt  (ratio_nxt)
    );

    dmod_period i_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .ratio_cur  (ratio_cur),
        .period_end (period_end),
        .run_d_o    (run_d),
        .cnt_d_o    (cnt_d)
    );

    dmod_outgate i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_d    (run_d),
        .cnt_d    (cnt_d),
        .ratio_d  (ratio_nxt),
        .byp_on   (byp_on),
        .gate_req (ctrl0_i[C0_OGATE]),
        .tick_o   (tick_o),
        .wave_o   (wave_o)
    );

    // R6: input gate low silences both outputs on the next cycle
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl0_i[C0_IGATE] |=> (!tick_o && !wave_o));

    // R9: bypass with both gates open yields a pulse every cycle
    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1_i[C1_BYPASS] && ctrl0_i[C0_IGATE] && ctrl0_i[C0_OGATE])
        |=> (tick_o && !wave_o));

endmodule

// File: tb/test_dmod_clk_div.sv
module test_dmod_clk_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl0 = '0;
    logic [31:0] ctrl1 = '0;
    logic        tick_o, wave_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    dmod_clk_div i_dmod_clk_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl0_i (ctrl0),
        .ctrl1_i (ctrl1),
        .tick_o  (tick_o),
        .wave_o  (wave_o)
    );

    function automatic logic [31:0] w0(int a, int b, bit dual, bit og, bit ig);
        logic [11:0] a12 = a[11:0];
        logic [11:0] b12 = b[11:0];
        return {ig, og, 1'b0, dual, 4'b0, b12, a12};
    endfunction

    function automatic logic [31:0] w1(int ma, int mb, bit byp);
        logic [11:0] ma12 = ma[11:0];
        logic [11:0] mb12 = mb[11:0];
        return {7'b0, byp, mb12, ma12};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // hold input gate low for a few cycles, then raise it
    task automatic restart(logic [31:0] c0, logic [31:0] c1);
        ctrl0 = c0 & 32'h7fff_ffff;
        ctrl1 = c1;
        repeat (3) @(negedge clk);
        ctrl0 = c0;
    endtask

    task automatic next_tick(output int gap, output int hi);
        gap = 0;
        hi  = 0;
        do begin
            @(negedge clk);
            gap++;
            if (wave_o) hi++;
        end while (!tick_o);
    endtask

    task automatic t_reset();
        chk(!tick_o && !wave_o, "R1 in reset", int'({tick_o, wave_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!tick_o && !wave_o, "R1 after reset", int'({tick_o, wave_o}), 0);
    endtask

    task automatic t_single();
        int g, h;
        restart(w0(9, 0, 0, 1, 1), w1(3, 0, 0));
        for (int i = 0; i < 3; i++) begin
            next_tick(g, h);
            chk(g == 10, "R2 ratio 10 gap", g, 10);
            chk(h == 5, "R3 ratio 10 high", h, 5);
        end
        restart(w0(6, 0, 0, 1, 1), w1(0, 0, 0));
        for (int i = 0; i < 2; i++) begin
            next_tick(g, h);
            chk(g == 7, "R2 ratio 7 gap", g, 7);
            chk(h == 3, "R3 ratio 7 high", h, 3);
        end
    endtask

    task automatic t_gate_in();
        int g, h, cnt;
        ctrl1 = w1(1, 2, 0);
        ctrl0 = w0(4, 6, 1, 1, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick_o || wave_o) cnt++;
        end
        chk(cnt == 0, "R6 quiet while input gate low", cnt, 0);
        ctrl0 = w0(4, 6, 1, 1, 1);
        for (int i = 0; i < 10; i++) begin
            int eg = ((i % 5) < 2) ? 5 : 7;
            next_tick(g, h);
            chk(g == eg, "R4 R6 dual period sequence", g, eg);
            chk(h == eg / 2, "R3 dual high time", h, eg / 2);
        end
    endtask

    task automatic t_target();
        int g, h, sum;
        sum = 0;
        restart(w0(732, 731, 1, 1, 1), w1(7, 10, 0));
        for (int i = 0; i < 19; i++) begin
            int eg = (i < 8) ? 733 : 732;
            next_tick(g, h);
            sum += g;
            chk(g == eg, "R5 period length", g, eg);
        end
        chk(sum == 13916, "R5 group length", sum, 13916);
    endtask

    task automatic t_update();
        int g, h;
        restart(w0(3, 0, 0, 1, 1), w1(2, 0, 0));
        ctrl0 = w0(5, 0, 0, 1, 1);
        for (int i = 0; i < 6; i++) begin
            int eg = (i < 3) ? 4 : 6;
            next_tick(g, h);
            chk(g == eg, "R8 change at group end", g, eg);
        end
    endtask

    task automatic t_out_gate();
        int g, h, hi, tk;
        restart(w0(9, 0, 0, 1, 1), w1(0, 0, 0));
        hi = 0;
        tk = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (wave_o) hi++;
        end
        ctrl0 = w0(9, 0, 0, 0, 1);
        for (int i = 0; i < 28; i++) begin
            @(negedge clk);
            if (wave_o) hi++;
            if (tick_o) tk++;
        end
        chk(hi == 5, "R7 close lets high finish", hi, 5);
        chk(tk == 0, "R7 no tick after close", tk, 0);
        restart(w0(9, 0, 0, 0, 1), w1(0, 0, 0));
        repeat (2) @(negedge clk);
        ctrl0 = w0(9, 0, 0, 1, 1);
        next_tick(g, h);
        chk(g == 8, "R7 open waits for low phase", g, 8);
        chk(h == 0, "R7 no partial high", h, 0);
        next_tick(g, h);
        chk(h == 5, "R7 first full period high", h, 5);
        chk(g == 10, "R7 first full period gap", g, 10);
    endtask

    task automatic t_bypass();
        int tk, wv;
        ctrl0 = w0(9, 3, 1, 1, 1);
        ctrl1 = w1(2, 2, 1);
        @(negedge clk);
        tk = 0;
        wv = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick_o) tk++;
            if (wave_o) wv++;
        end
        chk(tk == 10, "R9 bypass tick every cycle", tk, 10);
        chk(wv == 0, "R9 bypass wave low", wv, 0);
        ctrl0 = w0(9, 3, 1, 1, 0);
        @(negedge clk);
        tk = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (tick_o) tk++;
        end
        chk(tk == 0, "R9 bypass needs input gate", tk, 0);
        ctrl1 = w1(2, 2, 0);
    endtask

    task automatic t_ratio_one();
        int tk, wv;
        restart(w0(0, 0, 0, 1, 1), w1(0, 0, 0));
        tk = 0;
        wv = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick_o) tk++;
            if (wave_o) wv++;
        end
        chk(tk == 10, "R10 ratio one ticks", tk, 10);
        chk(wv == 0, "R10 ratio one wave low", wv, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_gate_in();
        t_target();
        t_update();
        t_out_gate();
        t_bypass();
        t_ratio_one();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule